// File: doc/BRIEF.md
# Address-Window Chip-Select Port

This block is a four-pin general-purpose port in which every pin is set up on its own. A pin either works as ordinary bidirectional I/O, driving a latched value and reporting the level it sees, or it becomes a chip-select strobe for an external peripheral. A strobe pin compares the external bus address with its own 16-bit base address. It asserts only while the chosen bus strobe (read, write or either) is low and the address falls inside the pin's window.

Each window is the base address with zero to three low address bits ignored, so a pin can cover 1, 2, 4 or 8 consecutive addresses. The active level of each strobe is programmable. The two upper pins can also raise external interrupt requests on a falling edge of their synchronised input while they are in I/O mode. Configuration goes in through a simple byte-wide register write port. All pin outputs are registered.

Top module: `csel_port`

## Requirements
- R1: After a synchronous reset, pin_out is 4'b1111, pin_oe is 4'b0000 and irq_req is 2'b00. All pins are in I/O mode with output latches at 1, no inversion, zero masks, zero bases and interrupts disabled.
- R2: In I/O mode (mode code 0), pin i drives the output latch bit i (register 0, bit i) on pin_out[i]. pin_oe[i] is high only while that latch bit is 0.
- R3: pin_level[i] reports pin_in[i] after a chain of two synchronising flip-flops, whatever the pin's mode.
- R4: Pin i's 2-bit mode is held in register 1, bits [2i+1:2i]. Code 1 fires the strobe on a bus read (bus_rd_n low), code 2 on a bus write (bus_wr_n low), and code 3 on either. In codes 1 to 3, pin_oe[i] is 1 and the output latch has no effect on the pin.
- R5: A strobe pin compares all 16 bus address bits with its base address. For pin i, the base low byte is register 4+2i and the high byte is register 5+2i.
- R6: Pin i's mask code (register 2, bits [2i+1:2i]) removes the low address bits from the comparison: 0 removes none, 1 removes A0, 2 removes A0 and A1, and 3 removes A0 to A2.
- R7: Register 3 bit i selects the strobe polarity of pin i. With 0 the strobe is active low and idles high. With 1 it is active high and idles low.
- R8: Pin outputs are registered. They change at the first rising clock edge after the bus or configuration inputs change, and not before it.
- R9: irq_req[0] watches pin 2 and irq_req[1] watches pin 3. Each is enabled by register 3 bit 4 or bit 5 respectively. A falling edge of the synchronised input of a pin in I/O mode produces a single-cycle pulse.
- R10: No interrupt pulse occurs when the enable bit is 0, when the pin is in a strobe mode, or on a rising edge.
- R11: Writes to configuration addresses 12 to 15 change nothing visible at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | External bus address |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pin_in | input | 4 | Sampled pad levels |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |
| pin_level | output | 4 | Synchronised pin levels for reads |
| irq_req | output | 2 | External interrupt request pulses |

## Verification
Strobe pins are exercised with addresses just below, at, inside and just past each window, for every mask width. These cases separate a correct masked comparison from one that ignores too many or too few bits. Read-only, write-only and mixed accesses are applied to pins in each strobe mode, which tells the three gating codes apart, and both polarities are used so that an inverted idle level shows up. Random configurations with addresses clustered near the bases then mix every mode, mask and polarity. Falling edges, rising edges, disabled enables and strobe-mode pins are all applied to the interrupt pins, which separates a true edge detector from a level detector or one that ignores the gating.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    MODE_GPIO = 2'd0,
    MODE_RD   = 2'd1,
    MODE_WR   = 2'd2,
    MODE_RW   = 2'd3
  } pin_mode_e;

  // configuration register indices
  localparam int REG_LATCH  = 0;
  localparam int REG_MODE   = 1;
  localparam int REG_MASK   = 2;
  localparam int REG_POLIRQ = 3;
  localparam int REG_BASE0  = 4;

endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int CFG_AW = 4,
  parameter int NIRQ   = 2,
  parameter int MASKW  = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [DW-1:0]                    cfg_wdata,
  output logic [NPINS-1:0]                 latch_o,
  output logic [NPINS-1:0][1:0]            mode_o,
  output logic [NPINS-1:0][MASKW-1:0]      mask_o,
  output logic [NPINS-1:0]                 inv_o,
  output logic [NIRQ-1:0]                  irq_en_o,
  output logic [NPINS-1:0][AW-1:0]         base_o
);

  localparam int BYTES = AW / DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_o  <= '1;
      mode_o   <= '0;
      mask_o   <= '0;
      inv_o    <= '0;
      irq_en_o <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(REG_LATCH))
        latch_o <= cfg_wdata[NPINS-1:0];
      if (cfg_addr == CFG_AW'(REG_MODE))
        mode_o <= cfg_wdata[2*NPINS-1:0];
      if (cfg_addr == CFG_AW'(REG_MASK))
        mask_o <= cfg_wdata[MASKW*NPINS-1:0];
      if (cfg_addr == CFG_AW'(REG_POLIRQ)) begin
        inv_o    <= cfg_wdata[NPINS-1:0];
        irq_en_o <= cfg_wdata[NPINS +: NIRQ];
      end
    end
  end

  for (genvar gp = 0; gp < NPINS; gp++) begin : g_pin
    for (genvar gb = 0; gb < BYTES; gb++) begin : g_byte
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(REG_BASE0 + gp*BYTES + gb))
          q <= cfg_wdata;
      end
      assign base_o[gp][gb*DW +: DW] = q;
    end
  end

endmodule

// File: rtl/csel_strobe.sv
module csel_strobe
  import csel_pkg::*;
#(
  parameter int AW    = 16,
  parameter int MASKW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    base,
  input  logic [MASKW-1:0] mask,
  input  logic [1:0]       mode,
  input  logic             inv,
  input  logic             latch,
  output logic             pin_out,
  output logic             pin_oe
);

  logic [AW-1:0] keep;
  logic          hit;
  logic          fire;

  always_comb begin
    keep = {AW{1'b1}} << mask;
    hit  = ((addr ^ base) & keep) == '0;
    fire = hit & ((mode[0] & ~rd_n) | (mode[1] & ~wr_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b1;
      pin_oe  <= 1'b0;
    end else if (mode == MODE_GPIO) begin
      pin_out <= latch;
      pin_oe  <= ~latch;
    end else begin
      pin_out <= fire ^ ~inv;
      pin_oe  <= 1'b1;
    end
  end

  // R2: I/O mode drives the latch, enable only for a low latch
  assert_gpio_follows_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_GPIO) |=> (pin_out == $past(latch) && pin_oe == !$past(latch)));

  // R4/R7: strobe pin with no bus access sits at its idle level
  assert_idle_without_access_R4: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_GPIO && rd_n && wr_n) |=> (pin_out == !$past(inv) && pin_oe));

  // R5: unmasked compare rejects any differing address
  assert_full_compare_R5: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_GPIO && mask == '0 && addr != base) |=> (pin_out == !$past(inv)));

endmodule

// File: rtl/csel_sync.sv
module csel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/csel_port.sv
module csel_port
  import csel_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int CFG_AW      = 4,
  parameter int NIRQ        = 2,
  parameter int MASKW       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_level,
  output logic [NIRQ-1:0]   irq_req
);

  localparam int IRQ_BASE = NPINS - NIRQ;

  logic [NPINS-1:0]            latch_w;
  logic [NPINS-1:0][1:0]       mode_w;
  logic [NPINS-1:0][MASKW-1:0] mask_w;
  logic [NPINS-1:0]            inv_w;
  logic [NIRQ-1:0]             irq_en_w;
  logic [NPINS-1:0][AW-1:0]    base_w;

  csel_regs #(
    .NPINS(NPINS), .AW(AW), .DW(DW), .CFG_AW(CFG_AW), .NIRQ(NIRQ), .MASKW(MASKW)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .latch_o(latch_w), .mode_o(mode_w), .mask_o(mask_w), .inv_o(inv_w),
    .irq_en_o(irq_en_w), .base_o(base_w)
  );

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    csel_strobe #(.AW(AW), .MASKW(MASKW)) u_strobe (
      .clk(clk), .rst(rst), .addr(bus_addr), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
      .base(base_w[gi]), .mask(mask_w[gi]), .mode(mode_w[gi]), .inv(inv_w[gi]),
      .latch(latch_w[gi]), .pin_out(pin_out[gi]), .pin_oe(pin_oe[gi])
    );
    csel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_in[gi]), .q(pin_level[gi])
    );
  end

  logic [NIRQ-1:0] prev_q;
  logic [NIRQ-1:0] irq_q;

  for (genvar gk = 0; gk < NIRQ; gk++) begin : g_irq
    logic armed;
    assign armed = irq_en_w[gk] && (mode_w[IRQ_BASE+gk] == MODE_GPIO);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[gk] <= 1'b1;
        irq_q[gk]  <= 1'b0;
      end else begin
        prev_q[gk] <= pin_level[IRQ_BASE+gk];
        irq_q[gk]  <= armed & prev_q[gk] & ~pin_level[IRQ_BASE+gk];
      end
    end

    // R9: a request lasts exactly one cycle
    assert_irq_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      irq_q[gk] |=> !irq_q[gk]);

    // R10: no request unless enabled and in I/O mode
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
      !armed |=> !irq_q[gk]);
  end

  assign irq_req = irq_q;

endmodule

// File: tb/sim_csel_port.sv
module sim_csel_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_rd_n, bus_wr_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [3:0]  pin_in;
  logic [3:0]  pin_out, pin_oe, pin_level;
  logic [1:0]  irq_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_level(pin_level), .irq_req(irq_req)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench copy of what it has programmed
  logic [3:0]  m_latch, m_inv;
  logic [1:0]  m_en;
  logic [1:0]  m_mode [4];
  logic [1:0]  m_mask [4];
  logic [15:0] m_base [4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {oe[3:0], out[3:0]} expected one edge after these bus inputs
  function automatic logic [7:0] exp_vec(logic [15:0] a, logic r, logic w);
    logic [3:0] o, e;
    for (int i = 0; i < 4; i++) begin
      if (m_mode[i] == 2'd0) begin
        o[i] = m_latch[i];
        e[i] = ~m_latch[i];
      end else begin
        logic [15:0] keep;
        logic hit, f;
        keep = 16'hFFFF << m_mask[i];
        hit  = ((a ^ m_base[i]) & keep) == 16'h0;
        f    = hit && ((m_mode[i][0] && !r) || (m_mode[i][1] && !w));
        o[i] = f ? m_inv[i] : !m_inv[i];
        e[i] = 1'b1;
      end
    end
    return {e, o};
  endfunction

  task automatic wreg(int a, logic [7:0] d);
    cfg_addr  = 4'(a);
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic push_cfg();
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    wreg(0, {4'h0, m_latch});
    wreg(1, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
    wreg(2, {m_mask[3], m_mask[2], m_mask[1], m_mask[0]});
    wreg(3, {2'b00, m_en, m_inv});
    for (int i = 0; i < 4; i++) begin
      wreg(4 + 2*i, m_base[i][7:0]);
      wreg(5 + 2*i, m_base[i][15:8]);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus(string req, logic [15:0] a, logic r, logic w);
    bus_addr = a; bus_rd_n = r; bus_wr_n = w;
    @(posedge clk); @(negedge clk);
    chk(req, {24'h0, pin_oe, pin_out}, {24'h0, exp_vec(a, r, w)});
  endtask

  task automatic count_irq(int cyc, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int k = 0; k < cyc; k++) begin
      @(posedge clk); @(negedge clk);
      c0 += int'(irq_req[0]);
      c1 += int'(irq_req[1]);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, c1;
    logic [7:0] held;
    void'($urandom(32'h5eed));
    rst = 1'b1; bus_addr = '0; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pin_in = 4'hF;
    m_latch = 4'hF; m_inv = 4'h0; m_en = 2'b00;
    for (int i = 0; i < 4; i++) begin
      m_mode[i] = 2'd0; m_mask[i] = 2'd0; m_base[i] = 16'h0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", {28'h0, pin_out}, 32'hF);
    chk("R1 pin_oe", {28'h0, pin_oe}, 32'h0);
    chk("R1 irq_req", {30'h0, irq_req}, 32'h0);
    bus("R1 defaults after reset", 16'h0000, 1'b0, 1'b0);

    // R2 I/O mode latch drive
    m_latch = 4'b0101;
    push_cfg();
    chk("R2 pin_out", {28'h0, pin_out}, 32'h5);
    chk("R2 pin_oe", {28'h0, pin_oe}, 32'hA);

    // R3 synchronised level
    pin_in = 4'b1001;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R3 pin_level", {28'h0, pin_level}, 32'h9);
    pin_in = 4'hF;
    repeat (3) begin @(posedge clk); @(negedge clk); end

    // strobe windows: pin0 write, pin1 read, pin2 either, pin3 I/O
    m_mode[0] = 2'd2; m_mask[0] = 2'd2; m_base[0] = 16'h1234;
    m_mode[1] = 2'd1; m_mask[1] = 2'd0; m_base[1] = 16'hABCD;
    m_mode[2] = 2'd3; m_mask[2] = 2'd3; m_base[2] = 16'h00F0;
    m_mode[3] = 2'd0;
    m_inv = 4'b0001; m_latch = 4'b0010; m_en = 2'b00;
    push_cfg();
    bus("R4 idle strobes", 16'h1234, 1'b1, 1'b1);
    chk("R7 idle high-polarity pin0 low", {31'h0, pin_out[0]}, 32'h0);
    chk("R4 latch ignored pin1 idles high", {31'h0, pin_out[1]}, 32'h1);
    bus("R6 below window", 16'h1233, 1'b1, 1'b0);
    bus("R6 window start", 16'h1234, 1'b1, 1'b0);
    chk("R7 active-high strobe", {31'h0, pin_out[0]}, 32'h1);
    bus("R6 window end", 16'h1237, 1'b1, 1'b0);
    bus("R6 past window", 16'h1238, 1'b1, 1'b0);
    bus("R4 read ignored by write strobe", 16'h1235, 1'b0, 1'b1);
    bus("R5 read hit", 16'hABCD, 1'b0, 1'b1);
    chk("R7 active-low strobe", {31'h0, pin_out[1]}, 32'h0);
    bus("R5 neighbour miss", 16'hABCC, 1'b0, 1'b1);
    bus("R5 high byte miss", 16'hBBCD, 1'b0, 1'b1);
    bus("R4 write ignored by read strobe", 16'hABCD, 1'b1, 1'b0);
    bus("R6 mask3 read", 16'h00F7, 1'b0, 1'b1);
    bus("R6 mask3 write", 16'h00F0, 1'b1, 1'b0);
    bus("R6 mask3 outside", 16'h00F8, 1'b0, 1'b1);

    // R8 registered output: no change before the edge
    bus("R8 fire", 16'hABCD, 1'b0, 1'b1);
    held = {pin_oe, pin_out};
    bus_rd_n = 1'b1;
    #1;
    chk("R8 holds before edge", {24'h0, pin_oe, pin_out}, {24'h0, held});
    @(posedge clk); @(negedge clk);
    chk("R8 releases after edge", {24'h0, pin_oe, pin_out}, {24'h0, exp_vec(16'hABCD, 1'b1, 1'b1)});

    // R11 unused addresses
    for (int a = 12; a < 16; a++) wreg(a, 8'hFF);
    bus("R11 after unused writes idle", 16'h1234, 1'b1, 1'b1);
    bus("R11 after unused writes hit", 16'h1236, 1'b1, 1'b0);
    bus("R11 after unused writes read", 16'hABCD, 1'b0, 1'b1);

    // R9/R10 interrupts
    for (int i = 0; i < 4; i++) m_mode[i] = 2'd0;
    m_latch = 4'hF; m_inv = 4'h0; m_en = 2'b11;
    push_cfg();
    pin_in[2] = 1'b0;
    count_irq(8, c0, c1);
    chk("R9 pin2 fall pulse", 32'(c0), 32'd1);
    chk("R9 pin3 quiet", 32'(c1), 32'd0);
    chk("R3 level low", {31'h0, pin_level[2]}, 32'h0);
    pin_in[2] = 1'b1;
    count_irq(8, c0, c1);
    chk("R10 rising edge no pulse", 32'(c0), 32'd0);
    pin_in[3] = 1'b0;
    count_irq(8, c0, c1);
    chk("R9 pin3 fall pulse", 32'(c1), 32'd1);
    pin_in[3] = 1'b1;
    count_irq(8, c0, c1);
    m_en = 2'b00;
    push_cfg();
    pin_in[2] = 1'b0;
    count_irq(8, c0, c1);
    chk("R10 disabled no pulse", 32'(c0), 32'd0);
    pin_in[2] = 1'b1;
    count_irq(8, c0, c1);
    m_en = 2'b11; m_mode[3] = 2'd1; m_base[3] = 16'h4000;
    push_cfg();
    pin_in[3] = 1'b0;
    count_irq(8, c0, c1);
    chk("R10 strobe mode no pulse", 32'(c1), 32'd0);
    pin_in[3] = 1'b1;
    count_irq(8, c0, c1);

    // random mix of configurations and accesses
    for (int cfg = 0; cfg < 30; cfg++) begin
      for (int i = 0; i < 4; i++) begin
        m_mode[i] = 2'($urandom_range(3, 0));
        m_mask[i] = 2'($urandom_range(3, 0));
        m_base[i] = 16'($urandom());
      end
      m_latch = 4'($urandom()); m_inv = 4'($urandom()); m_en = 2'($urandom());
      push_cfg();
      for (int t = 0; t < 20; t++) begin
        int p;
        logic [15:0] a;
        p = $urandom_range(3, 0);
        a = ($urandom_range(3, 0) == 0) ? 16'($urandom())
                                        : m_base[p] ^ 16'($urandom_range(15, 0));
        bus("R4/R5/R6/R7 random", a, 1'($urandom()), 1'($urandom()));
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule